// File: doc/BRIEF.md
# Vector Map-Reduce Sequencer

This block runs a two-phase vector computation on a small register file that it owns. After a start request it issues one element-wise integer addition per element: each destination element takes the sum of the matching elements of two source vectors. It then folds the destination vector down to a single value with a fixed, tree-shaped series of pairwise additions. The final sum lands in the first destination element.

A host loads operands and reads results through a simple read/write port. A start request carries the vector length and three base register numbers. While the sequence runs, the block reports busy. It issues exactly one register write per clock cycle, and it raises a one-cycle done pulse after the last write.

The reduction order is fixed, so the intermediate values left in the destination vector are fully predictable. The order depends on associativity, so only wrapping integer addition is offered.

Top module: `vmr_seq`

## Requirements
- R1: After reset, busy and done are both low.
- R2: A start request is accepted only when busy is low and vl is 1, 2, 4 or 8 (a plain binary count on the 4-bit vl port). Any other start request is ignored and leaves busy low, the timing unchanged and every register untouched.
- R3: The first phase writes element i of the destination as source1 element i plus source2 element i, modulo 2^32. It does this for i = 0 to vl-1 in ascending order, one element per cycle.
- R4: The second phase works level by level with strides 1, 2, 4 and so on while the stride is below vl. At each level, for each k that is a multiple of twice the stride, destination element k becomes element k plus element k+stride. The highest k is issued first. For vl=4 the order is: element 2 += element 3, then element 0 += element 1, then element 0 += element 2.
- R5: When done, destination element 0 holds the sum of all 2*vl source elements modulo 2^32. The other destination elements hold exactly what the R4 order leaves in them.
- R6: With the destination base equal to the source1 base (in-place), the issue sequence and the results follow the same rules as R3 to R5.
- R7: An accepted request performs exactly 2*vl-1 register writes, one per cycle. The write in the cycle after the sampling edge of start is the first. done is high for exactly one cycle, the cycle after the last write, which is 2*vl-1 rising edges after the edge that sampled start. busy falls at the same edge at which done rises.
- R8: With vl=1, no reduction step is issued, and done rises one edge after the start edge.
- R9: host_rdata always shows the register addressed by host_addr, combinationally. A host write with host_we high is stored at the next edge only while busy is low. A host write made while busy is high is dropped.
- R10: Register numbers are formed as base plus element offset modulo 32, so a vector may wrap from register 31 to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start request, sampled at a rising edge |
| vl | input | 4 | Vector length (1, 2, 4 or 8) |
| dst_base | input | 5 | First destination register |
| src1_base | input | 5 | First register of source 1 |
| src2_base | input | 5 | First register of source 2 |
| host_we | input | 1 | Host write enable |
| host_addr | input | 5 | Host register number for read and write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register contents at host_addr |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The checker assumes that the start parameters are held while start is high. The bench drives them in the same negedge step that raises start.

The checker also assumes the source and destination windows do not partly overlap except in the exact in-place form. For that reason, every scenario uses disjoint windows, or a destination base equal to the source1 base. The wrapped case places its windows so that only the destination crosses register 31.

Requests that must be ignored are exercised in three ways:
- an illegal vl while idle;
- a second start while busy;
- a host write while busy.

In each case the bench follows up with host reads of the registers that could have been touched.

// File: rtl/vmr_pkg.sv
package vmr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAP  = 2'd1,
    PH_RED  = 2'd2
  } phase_e;

  // A legal vector length is a power of two between 1 and the maximum.
  function automatic logic vl_is_legal(input int v, input int maxv);
    return (v >= 1) && (v <= maxv) && ((v & (v - 1)) == 0);
  endfunction

  // Offset of the left (accumulating) element of a reduction pair.
  function automatic int red_left(input int pair, input int lvl);
    return pair << (lvl + 1);
  endfunction

  // Offset of the right (consumed) element of a reduction pair.
  function automatic int red_right(input int pair, input int lvl);
    return red_left(pair, lvl) + (1 << lvl);
  endfunction

endpackage

// File: rtl/vmr_regfile.sv
module vmr_regfile #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr [NRD],
  output logic [XLEN-1:0] rdata [NRD]
);

  logic [XLEN-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Reads are combinational so each step sees every earlier write.
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/vmr_ctrl.sv
module vmr_ctrl
  import vmr_pkg::*;
#(
  parameter int AW    = 5,
  parameter int MAXVL = 8,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int LVLN = $clog2(MAXVL) + 1,
  localparam int LVLW = (LVLN > 1) ? $clog2(LVLN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl,
  input  logic [AW-1:0]  dst_base,
  input  logic [AW-1:0]  src1_base,
  input  logic [AW-1:0]  src2_base,
  output logic           busy,
  output logic           done,
  output logic           eng_we,
  output logic           in_red,
  output logic [AW-1:0]  eng_waddr,
  output logic [AW-1:0]  op_a_addr,
  output logic [AW-1:0]  op_b_addr,
  output logic [AW-1:0]  dst_q,
  output logic [VLW-1:0] vl_q
);

  phase_e          phase;
  logic [AW-1:0]   s1_q, s2_q;
  logic [VLW-1:0]  idx, pair;
  logic [LVLW-1:0] lvl;
  logic            done_q;

  logic            accept;
  logic            map_last, lvl_last, red_last;
  logic [VLW-1:0]  off_l, off_r;

  assign accept = start && (phase == PH_IDLE) && vl_is_legal(int'(vl), MAXVL);

  assign off_l    = VLW'(red_left(int'(pair), int'(lvl)));
  assign off_r    = VLW'(red_right(int'(pair), int'(lvl)));
  assign map_last = (idx == vl_q - VLW'(1));
  assign lvl_last = (pair == '0);
  assign red_last = lvl_last && ((VLW'(2) << lvl) == vl_q);

  always_comb begin
    op_a_addr = s1_q + AW'(idx);
    op_b_addr = s2_q + AW'(idx);
    eng_waddr = dst_q + AW'(idx);
    if (phase == PH_RED) begin
      op_a_addr = dst_q + AW'(off_l);
      op_b_addr = dst_q + AW'(off_r);
      eng_waddr = dst_q + AW'(off_l);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      vl_q   <= VLW'(1);
      dst_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
      idx    <= '0;
      pair   <= '0;
      lvl    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept) begin
            phase <= PH_MAP;
            vl_q  <= vl;
            dst_q <= dst_base;
            s1_q  <= src1_base;
            s2_q  <= src2_base;
            idx   <= '0;
          end
        end
        PH_MAP: begin
          if (map_last) begin
            if (vl_q == VLW'(1)) begin
              phase  <= PH_IDLE;
              done_q <= 1'b1;
            end else begin
              phase <= PH_RED;
              lvl   <= '0;
              pair  <= (vl_q >> 1) - VLW'(1);
            end
          end else begin
            idx <= idx + VLW'(1);
          end
        end
        PH_RED: begin
          if (red_last) begin
            phase  <= PH_IDLE;
            done_q <= 1'b1;
          end else if (lvl_last) begin
            lvl  <= lvl + LVLW'(1);
            pair <= (vl_q >> (int'(lvl) + 2)) - VLW'(1);
          end else begin
            pair <= pair - VLW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign eng_we = busy;
  assign in_red = (phase == PH_RED);
  assign done   = done_q;

endmodule

// File: rtl/vmr_seq.sv
module vmr_seq #(
  parameter int NREGS = 32,
  parameter int XLEN  = 32,
  parameter int MAXVL = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [AW-1:0]   dst_base,
  input  logic [AW-1:0]   src1_base,
  input  logic [AW-1:0]   src2_base,
  input  logic            host_we,
  input  logic [AW-1:0]   host_addr,
  input  logic [XLEN-1:0] host_wdata,
  output logic [XLEN-1:0] host_rdata,
  output logic            busy,
  output logic            done
);

  // Element operation: wrapping integer addition (associative).
  function automatic logic [XLEN-1:0] elem_op(input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  logic            eng_we, in_red;
  logic [AW-1:0]   eng_waddr, op_a_addr, op_b_addr, dst_q;
  logic [VLW-1:0]  vl_q;
  logic            host_wr_ok;
  logic            rf_we;
  logic [AW-1:0]   rf_waddr;
  logic [XLEN-1:0] rf_wdata;
  logic [AW-1:0]   rf_raddr [3];
  logic [XLEN-1:0] rf_rdata [3];

  vmr_ctrl #(.AW(AW), .MAXVL(MAXVL)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vl        (vl),
    .dst_base  (dst_base),
    .src1_base (src1_base),
    .src2_base (src2_base),
    .busy      (busy),
    .done      (done),
    .eng_we    (eng_we),
    .in_red    (in_red),
    .eng_waddr (eng_waddr),
    .op_a_addr (op_a_addr),
    .op_b_addr (op_b_addr),
    .dst_q     (dst_q),
    .vl_q      (vl_q)
  );

  // The engine owns the write port while it runs. Host writes then drop.
  assign host_wr_ok  = host_we && !busy;
  assign rf_we       = eng_we || host_wr_ok;
  assign rf_waddr    = eng_we ? eng_waddr : host_addr;
  assign rf_wdata    = eng_we ? elem_op(rf_rdata[0], rf_rdata[1]) : host_wdata;
  assign rf_raddr[0] = op_a_addr;
  assign rf_raddr[1] = op_b_addr;
  assign rf_raddr[2] = host_addr;

  vmr_regfile #(.NREGS(NREGS), .XLEN(XLEN), .NRD(3)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  assign host_rdata = rf_rdata[2];

endmodule

// File: rtl/vmr_seq_chk.sv
module vmr_seq_chk
  import vmr_pkg::*;
#(
  parameter int AW    = 5,
  parameter int VLW   = 4,
  parameter int MAXVL = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [VLW-1:0] vl,
  input logic           busy,
  input logic           done,
  input logic           eng_we,
  input logic           in_red,
  input logic [AW-1:0]  eng_waddr,
  input logic [AW-1:0]  dst_q,
  input logic [VLW-1:0] vl_q
);

  logic [AW-1:0] red_off;
  logic [7:0]    wcnt;

  assign red_off = eng_waddr - dst_q;

  // Writes counted since the last done pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wcnt <= '0;
    else if (done) wcnt <= '0;
    else           wcnt <= wcnt + 8'(eng_we);
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done));

  assert_bad_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !vl_is_legal(int'(vl), MAXVL)) |=> !busy);

  assert_red_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_red |-> (int'(red_off) < int'(vl_q)));

  assert_write_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(wcnt) == 2 * int'(vl_q) - 1));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_no_red_vl1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_red |-> (vl_q != VLW'(1)));

  assert_no_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_we);

endmodule

bind vmr_seq vmr_seq_chk #(.AW(AW), .VLW(VLW), .MAXVL(MAXVL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vl        (vl),
  .busy      (busy),
  .done      (done),
  .eng_we    (eng_we),
  .in_red    (in_red),
  .eng_waddr (eng_waddr),
  .dst_q     (dst_q),
  .vl_q      (vl_q)
);

// File: tb/vmr_seq_test.sv
module vmr_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  vl = 4'd0;
  logic [4:0]  dst_base = '0, src1_base = '0, src2_base = '0;
  logic        host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        busy, done;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    int          addr;
    logic [31:0] val;
    int          req;
  } exp_t;

  exp_t        sb [$];
  logic [31:0] model [32];

  always #5 clk = ~clk;

  vmr_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .dst_base(dst_base), .src1_base(src1_base), .src2_base(src2_base),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input int req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 5'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // Monitor: pops expected register contents and compares them at the host port.
  task automatic drain();
    while (sb.size() > 0) begin
      exp_t e = sb.pop_front();
      @(negedge clk);
      host_addr = 5'(e.addr);
      #1;
      check(host_rdata == e.val, e.req, $sformatf("reg %0d", e.addr),
            longint'(host_rdata), longint'(e.val));
    end
  endtask

  // Driver: builds the expected outcome, starts the block and checks timing.
  // disturb: 0 none, 1 second start while busy (R2), 2 host write while busy (R9)
  task automatic run_op(input int n, input int d, input int s1, input int s2,
                        input int req, input int disturb);
    logic [31:0] total = 0;
    int          k = 0;
    for (int i = 0; i < n; i++)
      total += model[(s1 + i) % 32] + model[(s2 + i) % 32];
    // R3: element pass in ascending order
    for (int i = 0; i < n; i++)
      model[(d + i) % 32] = model[(s1 + i) % 32] + model[(s2 + i) % 32];
    // R4: strides doubling, highest pair first within a stride
    for (int s = 1; s < n; s = s * 2)
      for (int j = n - 2 * s; j >= 0; j = j - 2 * s)
        model[(d + j) % 32] = model[(d + j) % 32] + model[(d + j + s) % 32];
    for (int i = 0; i < n; i++)
      sb.push_back('{addr: (d + i) % 32, val: model[(d + i) % 32], req: req});
    sb.push_back('{addr: d % 32, val: total, req: 5});   // R5 total
    if (disturb == 2)
      sb.push_back('{addr: 31, val: model[31], req: 9});   // R9 dropped write

    @(negedge clk);
    start = 1'b1; vl = 4'(n);
    dst_base = 5'(d); src1_base = 5'(s1); src2_base = 5'(s2);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, 7, "busy after start", longint'(busy), 1);
    forever begin
      @(posedge clk);
      k++;
      @(negedge clk);
      start = 1'b0; host_we = 1'b0;
      if (done || k > 40) break;
      if (k == 2 && disturb == 1) begin
        start = 1'b1; vl = 4'd2; dst_base = 5'd31; src1_base = 5'd1; src2_base = 5'd3;
      end
      if (k == 2 && disturb == 2) begin
        host_we = 1'b1; host_addr = 5'd31; host_wdata = 32'hDEAD_BEEF;
      end
    end
    // R7 (and R8 for n=1): done lands 2n-1 edges after the start edge
    check(k == 2 * n - 1, (n == 1) ? 8 : 7, "edges to done", k, 2 * n - 1);
    check(busy == 1'b0, 7, "busy low with done", longint'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, 7, "done one cycle", longint'(done), 0);
    drain();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (2) @(negedge clk);
    // R1: reset state
    check(busy == 1'b0 && done == 1'b0, 1, "reset outputs", {busy, done}, 0);
    rst_n = 1'b1;

    // R9: load and read back every register
    for (int i = 0; i < 32; i++) begin
      model[i] = 32'h1357_9BDF * (i + 1) + 32'hF000_0000;
      host_write(i, model[i]);
    end
    for (int i = 0; i < 32; i++)
      sb.push_back('{addr: i, val: model[i], req: 9});
    drain();

    run_op(4, 8, 0, 4, 4, 0);      // R4: vl=4 order
    run_op(8, 16, 0, 8, 4, 0);     // R4: vl=8 generalised order
    run_op(2, 24, 2, 12, 3, 0);    // R3: vl=2
    run_op(1, 26, 4, 6, 8, 0);     // R8: vl=1
    run_op(4, 20, 20, 24, 6, 0);   // R6: in place
    run_op(4, 30, 2, 10, 10, 0);   // R10: destination wraps 31 -> 0
    run_op(8, 16, 0, 8, 2, 1);     // R2: start while busy ignored
    run_op(4, 8, 0, 4, 9, 2);      // R9: host write while busy dropped

    // R2: illegal vl ignored while idle
    @(negedge clk);
    start = 1'b1; vl = 4'd3; dst_base = 5'd0; src1_base = 5'd8; src2_base = 5'd16;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b0, 2, "vl=3 not accepted", longint'(busy), 0);
    repeat (8) @(negedge clk);
    check(done == 1'b0, 2, "no done for vl=3", longint'(done), 0);
    for (int i = 0; i < 3; i++)
      sb.push_back('{addr: i, val: model[i], req: 2});
    drain();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule